// File: doc/BRIEF.md
# Host-Loadable Masked Macrocell Register Bank

This block holds a bank of output flip-flops arranged as groups of eight. On every system clock edge internal logic drives each flip-flop through its own data, clock-enable, preset and clear inputs. A host processor reaches the same flip-flops over a small memory-mapped port: it can load a group with a byte and read it back. Each group has a write-protect mask, so selected bits can carry a state machine while the other bits of that group act as host-loaded counters, mailboxes or handshake flags.

A host write is committed when the active-low write strobe is released, not when it is asserted. On bits that the mask does not protect, the load overrides the internal clear, preset and clock for that cycle. Every flip-flop output is always available as internal feedback. For each pin the block also forms the driver enable as the OR of an internal enable term and that pin's direction bit.

Top module: `mcellBank`

## Requirements
- R1: Group g (default two groups of eight, 16 flip-flops in total) has its data location at address 2g and its mask location at address 2g+1. Address bit 0 selects mask, and the upper address bits select the group. `mcQ` bit g*8+b is bit b of group g.
- R2: After reset every flip-flop and every mask register reads 0x00, so all bits accept host writes.
- R3: A mask bit of 1 blocks host loads to the matching flip-flop. That bit then follows only the internal rule of R6.
- R4: The active-low write strobe is sampled on the clock. A load happens at the first clock edge where the strobe is seen high after it was seen low, using the address and data present at that edge. No load happens while the strobe is low.
- R5: On an unmasked bit of the addressed data location, the host load takes priority over clear, preset and clock enable in that cycle.
- R6: Without a host load, at each clock edge a bit is cleared if clear is 1. Otherwise it is set if preset is 1. Otherwise it takes D if the clock enable is 1. Otherwise it holds.
- R7: A write to a mask location changes only that mask register and leaves all flip-flops under the internal rule.
- R8: A read returns the current flip-flop byte at a data location or the mask byte at a mask location, combinationally from the address.
- R9: A read of an unmapped address (2*N_GROUPS and above) returns 0x00, and a write there changes no flip-flop and no mask.
- R10: Each pin enable `pinOe` equals `oeTerm` OR `dirBit` for that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Host address |
| busWrData | input | GRP_W | Host write data |
| busWrN | input | 1 | Active-low write strobe |
| busRdData | output | GRP_W | Host read data |
| mcD | input | N_GROUPS*GRP_W | Internal data input per flip-flop |
| mcClkEn | input | N_GROUPS*GRP_W | Internal clock enable per flip-flop |
| mcPre | input | N_GROUPS*GRP_W | Internal active-high preset |
| mcClr | input | N_GROUPS*GRP_W | Internal active-high clear |
| oeTerm | input | N_GROUPS*GRP_W | Internal output-enable term per pin |
| dirBit | input | N_GROUPS*GRP_W | Direction bit per pin |
| mcQ | output | N_GROUPS*GRP_W | Flip-flop outputs, also used as feedback |
| pinOe | output | N_GROUPS*GRP_W | Pin driver enable |

## Verification
The bench uses the default build: two groups of eight bits and a 3-bit address. With that build all eight locations can be swept, including the four unmapped ones. Sixteen steps that rotate every clear/preset/enable/D combination across the bits cover the whole internal rule. Host loads are then run against both masks and against active clear and preset, so every mix of mask bit and internal control is checked against an arithmetic model of the bank.

// File: rtl/mcellPkg.sv
package mcellPkg;
  // Decoded bus access, shared by control and datapath
  typedef struct packed {
    logic       load;    // one-cycle commit pulse (write only)
    logic       hit;     // address falls in a mapped group
    logic       isMask;  // mask location rather than data location
    logic [7:0] group;   // group index
  } ctrlStrb_t;
endpackage

// File: rtl/mcellCtrl.sv
module mcellCtrl
  import mcellPkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int N_GROUPS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrN,
  output ctrlStrb_t         wrStrb,
  output ctrlStrb_t         rdStrb
);
  localparam int GIDX_W = ADDR_W - 1;

  logic       wrNPrev;
  logic [7:0] grpIdx;
  logic       grpHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrNPrev <= 1'b1;
    else       wrNPrev <= busWrN;
  end

  assign grpIdx = 8'(busAddr[ADDR_W-1:1]);
  assign grpHit = (grpIdx < 8'(N_GROUPS)) && (GIDX_W <= 8);

  always_comb begin
    rdStrb.load   = 1'b0;
    rdStrb.hit    = grpHit;
    rdStrb.isMask = busAddr[0];
    rdStrb.group  = grpIdx;
    wrStrb        = rdStrb;
    wrStrb.load   = !wrNPrev && busWrN;
  end
endmodule

// File: rtl/mcellData.sv
module mcellData
  import mcellPkg::*;
#(
  parameter int N_GROUPS = 2,
  parameter int GRP_W    = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrb_t                 wrStrb,
  input  ctrlStrb_t                 rdStrb,
  input  logic [GRP_W-1:0]          busWrData,
  input  logic [N_GROUPS*GRP_W-1:0] mcD,
  input  logic [N_GROUPS*GRP_W-1:0] mcClkEn,
  input  logic [N_GROUPS*GRP_W-1:0] mcPre,
  input  logic [N_GROUPS*GRP_W-1:0] mcClr,
  input  logic [N_GROUPS*GRP_W-1:0] oeTerm,
  input  logic [N_GROUPS*GRP_W-1:0] dirBit,
  output logic [N_GROUPS*GRP_W-1:0] mcQ,
  output logic [N_GROUPS*GRP_W-1:0] pinOe,
  output logic [N_GROUPS*GRP_W-1:0] maskFlat,
  output logic [GRP_W-1:0]          busRdData
);
  localparam int NB = N_GROUPS * GRP_W;

  logic [NB-1:0] qReg;
  logic [NB-1:0] maskReg;

  for (genvar g = 0; g < N_GROUPS; g++) begin : gGroup
    logic dataSel;
    logic maskSel;
    assign dataSel = wrStrb.load && wrStrb.hit && !wrStrb.isMask && (wrStrb.group == 8'(g));
    assign maskSel = wrStrb.load && wrStrb.hit &&  wrStrb.isMask && (wrStrb.group == 8'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        maskReg[g*GRP_W +: GRP_W] <= '0;
      else if (maskSel) maskReg[g*GRP_W +: GRP_W] <= busWrData;
    end

    for (genvar b = 0; b < GRP_W; b++) begin : gBit
      localparam int IDX = g * GRP_W + b;
      logic hostHit;
      assign hostHit = dataSel && !maskReg[IDX];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              qReg[IDX] <= 1'b0;
        else if (hostHit)       qReg[IDX] <= busWrData[b];
        else if (mcClr[IDX])    qReg[IDX] <= 1'b0;
        else if (mcPre[IDX])    qReg[IDX] <= 1'b1;
        else if (mcClkEn[IDX])  qReg[IDX] <= mcD[IDX];
      end
    end
  end

  always_comb begin
    busRdData = '0;
    for (int g = 0; g < N_GROUPS; g++) begin
      if (rdStrb.hit && rdStrb.group == 8'(g))
        busRdData = rdStrb.isMask ? maskReg[g*GRP_W +: GRP_W] : qReg[g*GRP_W +: GRP_W];
    end
  end

  assign mcQ      = qReg;
  assign maskFlat = maskReg;
  assign pinOe    = oeTerm | dirBit;
endmodule

// File: rtl/mcellBank.sv
module mcellBank
  import mcellPkg::*;
#(
  parameter int N_GROUPS = 2,
  parameter int GRP_W    = 8,
  parameter int ADDR_W   = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [GRP_W-1:0]          busWrData,
  input  logic                      busWrN,
  output logic [GRP_W-1:0]          busRdData,
  input  logic [N_GROUPS*GRP_W-1:0] mcD,
  input  logic [N_GROUPS*GRP_W-1:0] mcClkEn,
  input  logic [N_GROUPS*GRP_W-1:0] mcPre,
  input  logic [N_GROUPS*GRP_W-1:0] mcClr,
  input  logic [N_GROUPS*GRP_W-1:0] oeTerm,
  input  logic [N_GROUPS*GRP_W-1:0] dirBit,
  output logic [N_GROUPS*GRP_W-1:0] mcQ,
  output logic [N_GROUPS*GRP_W-1:0] pinOe
);
  ctrlStrb_t                 wrStrb;
  ctrlStrb_t                 rdStrb;
  logic [N_GROUPS*GRP_W-1:0] maskFlat;
  logic                      ldPulse;

  mcellCtrl #(.ADDR_W(ADDR_W), .N_GROUPS(N_GROUPS)) ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrN(busWrN),
    .wrStrb(wrStrb), .rdStrb(rdStrb)
  );

  mcellData #(.N_GROUPS(N_GROUPS), .GRP_W(GRP_W)) dp (
    .clk(clk), .rstN(rstN), .wrStrb(wrStrb), .rdStrb(rdStrb),
    .busWrData(busWrData), .mcD(mcD), .mcClkEn(mcClkEn), .mcPre(mcPre),
    .mcClr(mcClr), .oeTerm(oeTerm), .dirBit(dirBit), .mcQ(mcQ),
    .pinOe(pinOe), .maskFlat(maskFlat), .busRdData(busRdData)
  );

  assign ldPulse = wrStrb.load;
endmodule

// File: rtl/mcellBankChk.sv
module mcellBankChk #(
  parameter int N_GROUPS = 2,
  parameter int GRP_W    = 8,
  parameter int ADDR_W   = 3
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [ADDR_W-1:0]         busAddr,
  input logic [GRP_W-1:0]          busWrData,
  input logic                      busWrN,
  input logic [GRP_W-1:0]          busRdData,
  input logic [N_GROUPS*GRP_W-1:0] mcClr,
  input logic [N_GROUPS*GRP_W-1:0] oeTerm,
  input logic [N_GROUPS*GRP_W-1:0] dirBit,
  input logic [N_GROUPS*GRP_W-1:0] mcQ,
  input logic [N_GROUPS*GRP_W-1:0] pinOe,
  input logic [N_GROUPS*GRP_W-1:0] maskFlat,
  input logic                      ldPulse
);
  localparam int NB = N_GROUPS * GRP_W;

  logic [NB-1:0] ldVec;
  always_comb begin
    ldVec = '0;
    for (int g = 0; g < N_GROUPS; g++)
      if (ldPulse && busAddr == ADDR_W'(2 * g))
        ldVec[g*GRP_W +: GRP_W] = ~maskFlat[g*GRP_W +: GRP_W];
  end

  // R2
  mask_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> maskFlat == '0);

  // R4
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWrN |-> !ldPulse);

  // R5
  host_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldPulse |=> ((mcQ ^ {N_GROUPS{$past(busWrData)}}) & $past(ldVec)) == '0);

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (mcQ & $past(mcClr & ~ldVec)) == '0);

  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr >= ADDR_W'(2 * N_GROUPS)) |-> busRdData == '0);

  // R10
  pin_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((dirBit & ~pinOe) == '0) && ((pinOe & ~(dirBit | oeTerm)) == '0));
endmodule

bind mcellBank mcellBankChk #(.N_GROUPS(N_GROUPS), .GRP_W(GRP_W), .ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
  .busWrN(busWrN), .busRdData(busRdData), .mcClr(mcClr), .oeTerm(oeTerm),
  .dirBit(dirBit), .mcQ(mcQ), .pinOe(pinOe), .maskFlat(maskFlat),
  .ldPulse(ldPulse)
);

// File: tb/mcellBank_test.sv
module mcellBank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 2;
  localparam int W  = 8;
  localparam int AW = 3;
  localparam int NB = NG * W;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [W-1:0]  busWrData = '0;
  logic          busWrN = 1'b1;
  logic [W-1:0]  busRdData;
  logic [NB-1:0] mcD = '0, mcClkEn = '0, mcPre = '0, mcClr = '0;
  logic [NB-1:0] oeTerm = '0, dirBit = '0;
  logic [NB-1:0] mcQ, pinOe;

  int cmpCnt = 0;
  int errCnt = 0;

  logic [NB-1:0] mQ = '0;
  logic [W-1:0]  mMask [NG];
  logic          mPrevWrN = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcellBank #(.N_GROUPS(NG), .GRP_W(W), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrN(busWrN), .busRdData(busRdData), .mcD(mcD), .mcClkEn(mcClkEn),
    .mcPre(mcPre), .mcClr(mcClr), .oeTerm(oeTerm), .dirBit(dirBit),
    .mcQ(mcQ), .pinOe(pinOe)
  );

  task automatic check(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    cmpCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expRead(input logic [AW-1:0] a);
    int g = int'(a[AW-1:1]);
    if (g >= NG) return '0;
    return a[0] ? mMask[g] : mQ[g*W +: W];
  endfunction

  task automatic rdCheck(input logic [AW-1:0] a, input string tag);
    busAddr = a;
    #1;
    check(tag, NB'(busRdData), NB'(expRead(a)));
  endtask

  // advance one clock, updating the model per R4..R7, R9
  task automatic step(input string tag);
    logic ld;
    logic [NB-1:0] nq;
    ld = !mPrevWrN && busWrN;
    for (int i = 0; i < NB; i++) begin
      int g = i / W;
      logic hostHit;
      hostHit = ld && busAddr == AW'(2 * g) && !mMask[g][i % W];
      if (hostHit)         nq[i] = busWrData[i % W];
      else if (mcClr[i])   nq[i] = 1'b0;
      else if (mcPre[i])   nq[i] = 1'b1;
      else if (mcClkEn[i]) nq[i] = mcD[i];
      else                 nq[i] = mQ[i];
    end
    for (int g = 0; g < NG; g++)
      if (ld && busAddr == AW'(2 * g + 1)) mMask[g] = busWrData;
    mPrevWrN = busWrN;
    @(posedge clk);
    mQ = nq;
    @(negedge clk);
    check(tag, mcQ, mQ);
    check(tag, NB'(busRdData), NB'(expRead(busAddr)));
    check("R10", pinOe, oeTerm | dirBit);
  endtask

  task automatic hostWrite(input logic [AW-1:0] a, input logic [W-1:0] d, input string tag);
    busAddr = a; busWrData = d; busWrN = 1'b0;
    step({tag, "/R4 strobe low"});
    step({tag, "/R4 strobe low"});
    busWrN = 1'b1;
    step(tag);
  endtask

  task automatic idleInternal();
    mcD = '0; mcClkEn = '0; mcPre = '0; mcClr = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, errCnt);
    $finish;
  end

  initial begin
    for (int g = 0; g < NG; g++) mMask[g] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R2: reset state of every location
    for (int a = 0; a < 8; a++) rdCheck(AW'(a), "R2");
    check("R2", mcQ, '0);

    // R1 / R8: data and mask locations per group
    for (int p = 0; p < 4; p++) begin
      for (int g = 0; g < NG; g++) begin
        hostWrite(AW'(2 * g), W'(8'h3C ^ (p * 8'h51) ^ (g * 8'h0F)), "R1");
        rdCheck(AW'(2 * g), "R8");
      end
    end
    hostWrite(AW'(1), 8'h5A, "R7");
    rdCheck(AW'(1), "R8");
    rdCheck(AW'(0), "R7");
    hostWrite(AW'(3), 8'hC0, "R7");
    rdCheck(AW'(3), "R8");
    hostWrite(AW'(1), 8'h00, "R7");
    hostWrite(AW'(3), 8'h00, "R7");

    // R6: every clr/pre/en/d combination rotated over the bits
    for (int k = 0; k < 16; k++) begin
      for (int i = 0; i < NB; i++) begin
        int c = (i + k) % 16;
        mcClr[i] = c[3]; mcPre[i] = c[2]; mcClkEn[i] = c[1]; mcD[i] = c[0];
      end
      step("R6");
    end
    idleInternal();

    // R5: host load beats clear and preset
    mcClr = '1;
    hostWrite(AW'(0), 8'hC3, "R5");
    mcClr = '0; mcPre = '1;
    hostWrite(AW'(2), 8'h18, "R5");
    mcPre = '0; mcClkEn = '1; mcD = 16'h0F0F;
    hostWrite(AW'(0), 8'hA0, "R5");
    idleInternal();

    // R3: masked bits follow the internal rule only
    hostWrite(AW'(1), 8'h0F, "R3");
    hostWrite(AW'(3), 8'hA5, "R3");
    for (int p = 0; p < 4; p++) begin
      mcClkEn = 16'hFFFF; mcD = 16'h6969 ^ NB'(p * 16'h1111);
      mcClr = NB'(p * 16'h0101); mcPre = NB'(p * 16'h2020);
      hostWrite(AW'(0), W'(8'hFF ^ (p * 8'h33)), "R3");
      hostWrite(AW'(2), W'(8'h00 ^ (p * 8'h47)), "R3");
    end
    idleInternal();
    hostWrite(AW'(1), 8'h00, "R3");
    hostWrite(AW'(3), 8'h00, "R3");

    // R9: unmapped locations
    for (int a = 2 * NG; a < 8; a++) begin
      hostWrite(AW'(a), 8'hFF, "R9");
      rdCheck(AW'(a), "R9");
    end
    for (int a = 0; a < 2 * NG; a++) rdCheck(AW'(a), "R9");

    // R10: enable combination sweep
    for (int p = 0; p < 4; p++) begin
      oeTerm = p[0] ? 16'hF0F0 : 16'h0000;
      dirBit = p[1] ? 16'h3C3C : 16'h0000;
      step("R10");
      oeTerm = ~oeTerm ^ NB'(p);
      step("R10");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, errCnt);
    $finish;
  end
endmodule